// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits on the bus side of a small 16-bit processor and keeps the instruction decoder supplied with code bytes. While the execution side is busy, it issues instruction fetches on a shared memory bus and stores the returned bytes in a short queue. The decoder reads them one at a time, in program order. The block owns a 20-bit fetch pointer. It advances that pointer by the number of bytes it stores, and it opens a new fetch only when there is room for the bytes that fetch can bring back.

When the execution side changes control flow, it pulses a flush together with the target address. The queue then empties, the pointer jumps to the target, and a fetch that is already in flight is allowed to finish on the bus, but its data is thrown away. The parameter `BUS_BYTES` chooses the build. With 2, the bus is a word bus and the queue holds six bytes. With 1, the bus is a byte bus and the queue holds four bytes.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted and right after it, `byte_valid_o` and `bus_req_o` are both low.
- R2: After a flush to address T, the decoder receives the memory bytes at T, T+1, T+2, … in that order, one per cycle in which `byte_pop_i` is high while `byte_valid_o` is high. A pause in popping of any length changes neither the order nor the values. Byte A of memory travels on `bus_rdata_i[7:0]` when A is even, and on `bus_rdata_i[15:8]` when A is odd.
- R3: The queue never holds more than 2*BUS_BYTES+2 bytes. A fetch is started only when at least BUS_BYTES slots are free. On the word bus, a queue with a single free slot therefore issues no request.
- R4: Once `bus_req_o` is raised, it stays high and `bus_addr_o` stays unchanged until `bus_ack_i` is seen, unless a flush withdraws the request.
- R5: On the word bus, `bus_addr_o[0]` is always 0. When the fetch pointer is odd, only the high byte of the returned word is stored, and every later fetch is word-aligned.
- R6: In the cycle after a flush, `byte_valid_o` is low.
- R7: Data returned for a fetch that was acknowledged before a flush, or in the same cycle as it, is never delivered. The first byte delivered after a flush is the byte at the target address.
- R8: On the byte bus, the queue holds four bytes. Each fetch brings one byte from `bus_rdata_i[7:0]` at exactly `bus_addr_o`, and a request may start with a single free slot.
- R9: A pop and a fill in the same cycle are both honoured, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Control-flow redirect pulse |
| flush_addr_i | input | AW | Target address of the redirect |
| byte_pop_i | input | 1 | Decoder takes the head byte |
| byte_valid_o | output | 1 | Head byte is present |
| byte_o | output | 8 | Head byte |
| bus_req_o | output | 1 | Fetch request, held until acknowledged |
| bus_ack_i | input | 1 | Bus accepts the request |
| bus_addr_o | output | AW | Fetch address |
| bus_rvalid_i | input | 1 | Fetch data returns |
| bus_rdata_i | input | 8*BUS_BYTES | Fetch data |

## Verification
A byte stored at a clock edge appears at the head one cycle later. A flush empties the queue at the edge it is sampled, so the bench checks `byte_valid_o` at the first falling edge after that edge. The bench model acknowledges a request after 0 to 2 cycles and returns the data three cycles after the acknowledge. Because of this, the bench never predicts the cycle in which a byte arrives. Instead, it compares each popped byte, sampled at the falling edge where the pop is driven, against the next expected memory byte. The threshold checks let the refill logic settle for several cycles before they test whether a request is present.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int AW = 20,
  parameter int BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_i,
  input  logic [AW-1:0]          flush_addr_i,
  input  logic                   byte_pop_i,
  output logic                   byte_valid_o,
  output logic [7:0]             byte_o,
  output logic                   bus_req_o,
  input  logic                   bus_ack_i,
  output logic [AW-1:0]          bus_addr_o,
  input  logic                   bus_rvalid_i,
  input  logic [8*BUS_BYTES-1:0] bus_rdata_i
);
  localparam int QB = 2*BUS_BYTES + 2;
  localparam int CW = $clog2(QB + 1);
  localparam int IW = $clog2(QB);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} fstate_t;

  fstate_t          state;
  logic             drop;
  logic [7:0]       q [QB];
  logic [IW-1:0]    rd_ix, wr_ix;
  logic [CW-1:0]    cnt, free;
  logic [AW-1:0]    ptr;
  logic [7:0]       lane0, lane1;
  logic [1:0]       nfill;
  logic             start, take, pop;

  function automatic logic [IW-1:0] step_ix(input logic [IW-1:0] ix, input int n);
    int s;
    s = int'(ix) + n;
    if (s >= QB) s = s - QB;
    return IW'(s);
  endfunction

  generate
    if (BUS_BYTES == 2) begin : g_word
      assign bus_addr_o = {ptr[AW-1:1], 1'b0};
      assign lane0      = ptr[0] ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
      assign lane1      = bus_rdata_i[15:8];
      assign nfill      = take ? (ptr[0] ? 2'd1 : 2'd2) : 2'd0;
    end else begin : g_byte
      assign bus_addr_o = ptr;
      assign lane0      = bus_rdata_i[7:0];
      assign lane1      = bus_rdata_i[7:0];
      assign nfill      = take ? 2'd1 : 2'd0;
    end
  endgenerate

  assign free         = CW'(QB) - cnt;
  assign start        = (state == S_IDLE) && !flush_i && (free >= CW'(BUS_BYTES));
  assign take         = (state == S_WAIT) && bus_rvalid_i && !drop && !flush_i;
  assign pop          = byte_pop_i && (cnt != '0) && !flush_i;
  assign bus_req_o    = (state == S_REQ);
  assign byte_valid_o = (cnt != '0);
  assign byte_o       = q[rd_ix];

  always_ff @(posedge clk) begin
    if (take) begin
      q[wr_ix] <= lane0;
      if (nfill == 2'd2) q[step_ix(wr_ix, 1)] <= lane1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      drop  <= 1'b0;
      cnt   <= '0;
      rd_ix <= '0;
      wr_ix <= '0;
      ptr   <= '0;
    end else if (flush_i) begin
      cnt   <= '0;
      rd_ix <= '0;
      wr_ix <= '0;
      ptr   <= flush_addr_i;
      case (state)
        S_REQ: begin
          state <= bus_ack_i ? S_WAIT : S_IDLE;
          drop  <= bus_ack_i;
        end
        S_WAIT: begin
          state <= bus_rvalid_i ? S_IDLE : S_WAIT;
          drop  <= !bus_rvalid_i;
        end
        default: begin
          state <= S_IDLE;
          drop  <= 1'b0;
        end
      endcase
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_REQ;
        S_REQ:   if (bus_ack_i) state <= S_WAIT;
        default: if (bus_rvalid_i) begin
          state <= S_IDLE;
          drop  <= 1'b0;
        end
      endcase
      if (take) begin
        wr_ix <= step_ix(wr_ix, int'(nfill));
        ptr   <= ptr + AW'(nfill);
      end
      if (pop) rd_ix <= step_ix(rd_ix, 1);
      cnt <= cnt + CW'(nfill) - CW'(pop);
    end
  end
endmodule

module prefetch_queue_checker #(
  parameter int AW = 20,
  parameter int BUS_BYTES = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               flush_i,
  input logic                               bus_req_o,
  input logic                               bus_ack_i,
  input logic [AW-1:0]                      bus_addr_o,
  input logic                               byte_valid_o,
  input logic [$clog2(2*BUS_BYTES+3)-1:0]   cnt
);
  localparam int QB = 2*BUS_BYTES + 2;

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i && !flush_i |=> bus_req_o);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i && !flush_i |=> $stable(bus_addr_o));

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !byte_valid_o);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= QB);

  p_start_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> (QB - int'(cnt)) >= BUS_BYTES);

  p_even_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (BUS_BYTES == 2) && bus_req_o |-> !bus_addr_o[0]);
endmodule

bind prefetch_queue prefetch_queue_checker #(.AW(AW), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .bus_req_o(bus_req_o),
  .bus_ack_i(bus_ack_i), .bus_addr_o(bus_addr_o), .byte_valid_o(byte_valid_o),
  .cnt(cnt)
);

// File: tb/test_prefetch_queue.sv
module pq_bus_model #(
  parameter int BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [19:0]            addr,
  output logic                   ack,
  output logic                   rvalid,
  output logic [8*BUS_BYTES-1:0] rdata
);
  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  int cyc = 0;
  int waitc = 0;
  int left = 0;
  bit inflight = 0;
  logic [19:0] a_l = '0;

  initial begin
    ack = 0;
    rvalid = 0;
    rdata = '0;
  end

  always @(negedge clk) begin
    cyc++;
    ack = 0;
    rvalid = 0;
    if (!rst_n) begin
      inflight = 0;
      waitc = 0;
      left = 0;
    end else if (inflight) begin
      if (left == 1) begin
        rvalid = 1;
        if (BUS_BYTES == 2) rdata = (8*BUS_BYTES)'({mem_byte(a_l | 20'd1), mem_byte(a_l & ~20'd1)});
        else rdata = (8*BUS_BYTES)'(mem_byte(a_l));
        inflight = 0;
      end
      left--;
    end else if (req) begin
      if (waitc == 0) begin
        ack = 1;
        inflight = 1;
        left = 3;
        a_l = addr;
        waitc = cyc % 3;
      end else waitc--;
    end
  end
endmodule

module test_prefetch_queue;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic        flush_w = 0, pop_w = 0, flush_n = 0, pop_n = 0;
  logic [19:0] fa_w = '0, fa_n = '0;
  logic        bv_w, bv_n, req_w, req_n, ack_w, ack_n, rv_w, rv_n;
  logic [7:0]  bd_w, bd_n;
  logic [19:0] addr_w, addr_n;
  logic [15:0] rd_w;
  logic [7:0]  rd_n;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  prefetch_queue #(.AW(20), .BUS_BYTES(2)) i_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_w), .flush_addr_i(fa_w),
    .byte_pop_i(pop_w), .byte_valid_o(bv_w), .byte_o(bd_w),
    .bus_req_o(req_w), .bus_ack_i(ack_w), .bus_addr_o(addr_w),
    .bus_rvalid_i(rv_w), .bus_rdata_i(rd_w));

  prefetch_queue #(.AW(20), .BUS_BYTES(1)) i_prefetch_queue_nb (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_n), .flush_addr_i(fa_n),
    .byte_pop_i(pop_n), .byte_valid_o(bv_n), .byte_o(bd_n),
    .bus_req_o(req_n), .bus_ack_i(ack_n), .bus_addr_o(addr_n),
    .bus_rvalid_i(rv_n), .bus_rdata_i(rd_n));

  pq_bus_model #(.BUS_BYTES(2)) u_bus_w (.clk(clk), .rst_n(rst_n), .req(req_w),
    .addr(addr_w), .ack(ack_w), .rvalid(rv_w), .rdata(rd_w));
  pq_bus_model #(.BUS_BYTES(1)) u_bus_n (.clk(clk), .rst_n(rst_n), .req(req_n),
    .addr(addr_n), .ack(ack_n), .rvalid(rv_n), .rdata(rd_n));

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  task automatic flush_to(input bit nar, input logic [19:0] t);
    @(negedge clk);
    pop_w = 0;
    pop_n = 0;
    if (nar) begin flush_n = 1; fa_n = t; end
    else begin flush_w = 1; fa_w = t; end
    @(negedge clk);
    flush_w = 0;
    flush_n = 0;
    check((nar ? bv_n : bv_w) == 1'b0, "R6 valid after flush", int'(nar ? bv_n : bv_w), 0);
  endtask

  function automatic bit want(input int pat, input int step);
    case (pat)
      0: return 1'b1;
      1: return (step % 2) == 0;
      2: return (step % 3) == 0;
      default: return (step % 8) < 5;
    endcase
  endfunction

  task automatic run(input bit nar, input logic [19:0] t, input int pat, input int ph, input string tag);
    int k = 0;
    int step = 0;
    bit odd_addr = 0;
    bit ok = 1;
    int bad_v = 0, bad_e = 0;
    repeat (ph) @(negedge clk);
    flush_to(nar, t);
    while (k < 16 && step < 400) begin
      logic v;
      logic [7:0] b;
      v = nar ? bv_n : bv_w;
      b = nar ? bd_n : bd_w;
      if (!nar && req_w && addr_w[0]) odd_addr = 1;
      if (v && want(pat, step)) begin
        if (ok && b !== mem_byte(t + 20'(k))) begin
          ok = 0;
          bad_v = int'(b);
          bad_e = int'(mem_byte(t + 20'(k)));
        end
        k++;
        if (nar) pop_n = 1; else pop_w = 1;
      end else begin
        pop_w = 0;
        pop_n = 0;
      end
      step++;
      @(negedge clk);
    end
    pop_w = 0;
    pop_n = 0;
    check(ok, tag, bad_v, bad_e);
    check(k == 16, {tag, " byte count"}, k, 16);
    if (!nar) check(!odd_addr, "R5 even bus address", int'(odd_addr), 0);
  endtask

  task automatic settle_no_req(input bit nar, input int n, input string tag);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (nar ? req_n : req_w) seen = 1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic expect_req(input bit nar, input int n, input string tag);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (nar ? req_n : req_w) seen = 1;
    end
    check(seen, tag, int'(seen), 1);
  endtask

  task automatic pop_one(input bit nar, input logic [7:0] exp, input string tag);
    @(negedge clk);
    check((nar ? bd_n : bd_w) == exp, tag, int'(nar ? bd_n : bd_w), int'(exp));
    if (nar) pop_n = 1; else pop_w = 1;
    @(negedge clk);
    pop_w = 0;
    pop_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bv_w == 0 && bv_n == 0, "R1 valid in reset", int'({bv_w, bv_n}), 0);
    check(req_w == 0 && req_n == 0, "R1 request in reset", int'({req_w, req_n}), 0);
    rst_n = 1;
    @(negedge clk);
    check(bv_w == 0 && bv_n == 0, "R1 valid after reset", int'({bv_w, bv_n}), 0);

    // R3: a full word-bus queue from an even target holds six bytes and stops fetching
    flush_to(0, 20'h00100);
    repeat (40) @(negedge clk);
    check(bv_w == 1, "R3 queue filled", int'(bv_w), 1);
    settle_no_req(0, 4, "R3 no fetch when full");
    pop_one(0, mem_byte(20'h00100), "R3 head byte");
    settle_no_req(0, 6, "R3 no fetch with one free slot");
    pop_one(0, mem_byte(20'h00101), "R3 second byte");
    expect_req(0, 6, "R3 fetch with two free slots");

    // R5: odd target stores a single high byte first, leaving one slot free when full
    flush_to(0, 20'h00201);
    repeat (40) @(negedge clk);
    settle_no_req(0, 6, "R5 odd start no fetch at five bytes");
    pop_one(0, mem_byte(20'h00201), "R5 high byte first");

    // R8: byte-bus queue fills four bytes and refills with one free slot
    flush_to(1, 20'h00300);
    repeat (40) @(negedge clk);
    settle_no_req(1, 4, "R8 no fetch when full");
    pop_one(1, mem_byte(20'h00300), "R8 head byte");
    expect_req(1, 6, "R8 fetch with one free slot");

    // R2 R7 R9 sweeps over targets, pop patterns and flush phases
    for (int nar = 0; nar < 2; nar++) begin
      for (int t = 0; t < 24; t++) begin
        for (int pat = 0; pat < 4; pat++) begin
          string tag;
          int ph;
          ph = (t + pat) % 5;
          if (nar == 1) tag = "R8 byte-bus order";
          else if (pat == 0) tag = "R9 pop with fill";
          else if (t % 2 == 1) tag = "R5 odd target order";
          else if (ph != 0) tag = "R7 flush over fetch";
          else tag = "R2 program order";
          run(nar[0], 20'h0F000 + 20'(t * 13), pat, ph, tag);
        end
      end
    end

    summary();
  end
endmodule